// File: doc/BRIEF.md
# Eight-Region Address Protection and Translation Unit

This block gives a processor without a paged MMU a simple form of address translation and access control. The 4 GB address space is cut into eight 512 MB regions picked by the top three address bits. The instruction side and the data side each hold their own eight-entry table. Each entry holds a physical region number and a 4-bit attribute code. The code is decoded into read, write and execute rights and a cache mode.

A request gives an address, an access kind and a side. One cycle later the block returns the physical address, the decoded rights, the cache mode and a fault cause. The cause is zero when the access is allowed. In the alternate bypass mode the tables are not used. The address passes through unchanged, and the attribute code for the region comes from a packed 32-bit cache-attribute word.

Top module: `rgn_xlate`

## Requirements
- R1: The region index is `req_addr[31:29]`. In table mode `rsp_paddr` is the selected entry's 3-bit physical region number placed in bits 31:29, with `req_addr[28:0]` copied unchanged below it.
- R2: After reset, entry i of both tables holds physical region number i and attribute code 2. Every region therefore maps to itself with full rights and the uncached (bypass) mode.
- R3: The decode in table mode is as follows. Codes 4 and 5 give read, write and execute, write-back. Code 2 gives read, write and execute, uncached. Code 1 gives read, write and execute, write-through. Code 0 gives read and write, write-through. Code 3 gives execute only, write-back. Code 14 gives read and write, isolate. Every other code gives no rights and cache mode none. `rsp_rights` is {read, write, execute} from bit 2 down to bit 0. `rsp_cache` uses 0 for none, 1 for uncached, 2 for write-through, 3 for write-back and 4 for isolate.
- R4: `req_acc` uses 0 for read, 1 for write, 2 for execute and 3 as reserved. A reserved access is never granted. `rsp_cause` is 0 when the needed right is present. When a right is missing, the instruction side (`req_side`=0) reports 1, fetch prohibited. The data side (`req_side`=1) reports 3, store prohibited, for a write, and 2, load prohibited, for any other access kind.
- R5: The write port updates only the table chosen by `wr_side`, at entry `wr_idx`. The other side's table is left unchanged.
- R6: When `bypass_mode` is 1, `rsp_paddr` equals `req_addr`. The attribute code is `ca_word[4*i+3:4*i]` for region i. It is decoded as in R3, except that code 5 gives no rights and cache mode none.
- R7: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high. The response fields hold their value while no request arrives.
- R8: A request in the same cycle as a table write to its entry sees the entry's old contents. The new contents apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_side | input | 1 | Table to write: 0 instruction, 1 data |
| wr_idx | input | 3 | Entry to write |
| wr_base | input | 3 | Physical region number to store |
| wr_attr | input | 4 | Attribute code to store |
| bypass_mode | input | 1 | 1 selects identity mapping with attributes from `ca_word` |
| ca_word | input | 32 | Packed attribute codes, four bits per region |
| req_valid | input | 1 | Request strobe |
| req_side | input | 1 | 0 instruction side, 1 data side |
| req_acc | input | 2 | Access kind (R4 encoding) |
| req_addr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | {read, write, execute} |
| rsp_cache | output | 3 | Cache mode (R3 encoding) |
| rsp_cause | output | 2 | Fault cause (R4 encoding), 0 for success |

## Verification
The assertions that look back one cycle assume that `req_addr`, `req_acc`, `req_side` and `bypass_mode` are stable from the driving edge through the capturing edge. The bench guarantees this by changing every input only on the falling clock edge. The assertions also assume that a reserved access kind still yields a defined cause. The bench drives that value once on purpose and otherwise uses only the three legal kinds. `ca_word` is held constant, so each bypass response depends only on the region index sampled with it.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2, ACC_RSV = 2'd3} acc_e;
  typedef enum logic [2:0] {CM_NONE = 3'd0, CM_UNCACHED = 3'd1, CM_WTHRU = 3'd2,
                            CM_WBACK = 3'd3, CM_ISOL = 3'd4} cmode_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_FETCH = 2'd1, FLT_LOAD = 2'd2,
                            FLT_STORE = 2'd3} flt_e;
  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rights_t;
endpackage

// File: rtl/rgn_attr_dec.sv
module rgn_attr_dec
  import rgn_pkg::*;
(
  input  logic [3:0] code,
  input  logic       alt,
  output rights_t    rts,
  output cmode_e     cm
);
  always_comb begin
    rts = '0;
    cm  = CM_NONE;
    unique case (code)
      4'd0:  begin rts = '{1'b1, 1'b1, 1'b0}; cm = CM_WTHRU;    end
      4'd1:  begin rts = '{1'b1, 1'b1, 1'b1}; cm = CM_WTHRU;    end
      4'd2:  begin rts = '{1'b1, 1'b1, 1'b1}; cm = CM_UNCACHED; end
      4'd3:  begin rts = '{1'b0, 1'b0, 1'b1}; cm = CM_WBACK;    end
      4'd4:  begin rts = '{1'b1, 1'b1, 1'b1}; cm = CM_WBACK;    end
      4'd5:  if (!alt) begin rts = '{1'b1, 1'b1, 1'b1}; cm = CM_WBACK; end
      4'd14: begin rts = '{1'b1, 1'b1, 1'b0}; cm = CM_ISOL;     end
      default: begin rts = '0; cm = CM_NONE; end
    endcase
  end

  // R3: an isolate page never grants execute; no cache mode means no rights
  always_comb begin
    a_r3_isolate_no_exec: assert (cm != CM_ISOL || !rts.x);
    a_r3_none_means_empty: assert ((cm == CM_NONE) == (rts == '0));
    // R6: code 5 is empty in the alternate decode
    a_r6_alt_code5_empty: assert (!(alt && code == 4'd5) || rts == '0);
  end
endmodule

// File: rtl/rgn_table.sv
module rgn_table #(
  parameter int IDX_W    = 3,
  parameter int ATTR_W   = 4,
  parameter logic [ATTR_W-1:0] RST_ATTR = 4'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [IDX_W-1:0]  wbase,
  input  logic [ATTR_W-1:0] wattr,
  input  logic [IDX_W-1:0]  ridx,
  output logic [IDX_W-1:0]  rbase,
  output logic [ATTR_W-1:0] rattr
);
  localparam int NREG = 1 << IDX_W;

  logic [IDX_W-1:0]  base_q [NREG];
  logic [ATTR_W-1:0] attr_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= IDX_W'(i);
        attr_q[i] <= RST_ATTR;
      end
    end else if (we) begin
      base_q[widx] <= wbase;
      attr_q[widx] <= wattr;
    end
  end

  assign rbase = base_q[ridx];
  assign rattr = attr_q[ridx];
endmodule

// File: rtl/rgn_xlate.sv
module rgn_xlate
  import rgn_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        wr_side,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [IDX_W-1:0]            wr_base,
  input  logic [3:0]                  wr_attr,
  input  logic                        bypass_mode,
  input  logic [(1<<IDX_W)*4-1:0]     ca_word,
  input  logic                        req_valid,
  input  logic                        req_side,
  input  logic [1:0]                  req_acc,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_valid,
  output logic [ADDR_W-1:0]           rsp_paddr,
  output logic [2:0]                  rsp_rights,
  output logic [2:0]                  rsp_cache,
  output logic [1:0]                  rsp_cause
);
  localparam int ATTR_W = 4;
  localparam int NREG   = 1 << IDX_W;
  localparam int OFS_W  = ADDR_W - IDX_W;
  localparam int CA_W   = NREG * ATTR_W;
  localparam int NSIDE  = 2;

  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  tab_base [NSIDE];
  logic [ATTR_W-1:0] tab_attr [NSIDE];

  assign idx = req_addr[ADDR_W-1 -: IDX_W];

  // one table per side, each with its own write enable
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    rgn_table #(.IDX_W(IDX_W), .ATTR_W(ATTR_W), .RST_ATTR(4'd2)) u_tab (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && (wr_side == 1'(s))),
      .widx  (wr_idx),
      .wbase (wr_base),
      .wattr (wr_attr),
      .ridx  (idx),
      .rbase (tab_base[s]),
      .rattr (tab_attr[s])
    );
  end

  logic [CA_W-1:0]   ca_sh;
  logic [ATTR_W-1:0] code;
  logic [ADDR_W-1:0] paddr_d;
  rights_t           rts;
  cmode_e            cm;
  logic              granted;
  flt_e              cause_d;

  assign ca_sh = ca_word >> (ATTR_W * int'(idx));

  always_comb begin
    if (bypass_mode) begin
      code    = ca_sh[ATTR_W-1:0];
      paddr_d = req_addr;
    end else begin
      code    = tab_attr[req_side];
      paddr_d = {tab_base[req_side], req_addr[OFS_W-1:0]};
    end
  end

  rgn_attr_dec u_dec (
    .code (code),
    .alt  (bypass_mode),
    .rts  (rts),
    .cm   (cm)
  );

  always_comb begin
    unique case (acc_e'(req_acc))
      ACC_RD:  granted = rts.r;
      ACC_WR:  granted = rts.w;
      ACC_EX:  granted = rts.x;
      default: granted = 1'b0;
    endcase
    if (granted)                 cause_d = FLT_NONE;
    else if (!req_side)          cause_d = FLT_FETCH;
    else if (req_acc == ACC_WR)  cause_d = FLT_STORE;
    else                         cause_d = FLT_LOAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_rights <= '0;
      rsp_cache  <= '0;
      rsp_cause  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr  <= paddr_d;
        rsp_rights <= rts;
        rsp_cache  <= cm;
        rsp_cause  <= cause_d;
      end
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(rsp_paddr) && $stable(rsp_cause));
  a_r1_offset_passes: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_paddr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]));
  a_r6_bypass_identity: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(bypass_mode) |-> rsp_paddr == $past(req_addr));
  a_r4_ok_has_right: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_cause == 2'd0 |-> rsp_rights != 3'd0);
  a_r4_read_fault_no_r: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(req_acc) == 2'd0 && rsp_cause != 2'd0 |-> !rsp_rights[2]);
  a_r4_instr_fault_fetch: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !$past(req_side) && rsp_cause != 2'd0 |-> rsp_cause == 2'd1);
endmodule

// File: tb/sim_rgn_xlate.sv
module sim_rgn_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_side = 1'b0;
  logic [2:0]  wr_idx = '0, wr_base = '0;
  logic [3:0]  wr_attr = '0;
  logic        bypass_mode = 1'b0;
  logic [31:0] ca_word = 32'hF5E4_3210;
  logic        req_valid = 1'b0, req_side = 1'b0;
  logic [1:0]  req_acc = '0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_rights, rsp_cache;
  logic [1:0]  rsp_cause;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rgn_xlate u0 (.*);

  // vector: side, acc, bypass, addr, cause, rwx, cache, paddr
  localparam int NV = 14;
  localparam logic [75:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 32'h2000_0010, 2'd0, 3'b110, 3'd2, 32'hA000_0010},
    {1'b1, 2'd1, 1'b0, 32'h2000_0010, 2'd0, 3'b110, 3'd2, 32'hA000_0010},
    {1'b1, 2'd2, 1'b0, 32'h2000_0010, 2'd2, 3'b110, 3'd2, 32'hA000_0010},
    {1'b0, 2'd2, 1'b0, 32'h2000_0004, 2'd0, 3'b001, 3'd3, 32'h4000_0004},
    {1'b0, 2'd0, 1'b0, 32'h2000_0004, 2'd1, 3'b001, 3'd3, 32'h4000_0004},
    {1'b1, 2'd1, 1'b0, 32'h6000_0000, 2'd3, 3'b001, 3'd3, 32'h0000_0000},
    {1'b1, 2'd0, 1'b0, 32'hE123_4567, 2'd0, 3'b110, 3'd4, 32'hE123_4567},
    {1'b1, 2'd2, 1'b0, 32'hE123_4567, 2'd2, 3'b110, 3'd4, 32'hE123_4567},
    {1'b1, 2'd0, 1'b1, 32'hA000_0100, 2'd0, 3'b110, 3'd4, 32'hA000_0100},
    {1'b0, 2'd2, 1'b1, 32'hC000_0000, 2'd1, 3'b000, 3'd0, 32'hC000_0000},
    {1'b1, 2'd0, 1'b1, 32'h8000_0000, 2'd0, 3'b111, 3'd3, 32'h8000_0000},
    {1'b1, 2'd1, 1'b1, 32'hE000_0000, 2'd3, 3'b000, 3'd0, 32'hE000_0000},
    {1'b1, 2'd3, 1'b0, 32'h4000_0000, 2'd2, 3'b111, 3'd1, 32'h4000_0000},
    {1'b0, 2'd2, 1'b1, 32'h6000_0000, 2'd0, 3'b001, 3'd3, 32'h6000_0000}
  };

  // expected decode from the R3 list: {rwx, cache}
  function automatic logic [5:0] exp_dec(input logic [3:0] c);
    case (c)
      4'd0: return {3'b110, 3'd2};
      4'd1: return {3'b111, 3'd2};
      4'd2: return {3'b111, 3'd1};
      4'd3: return {3'b001, 3'd3};
      4'd4, 4'd5: return {3'b111, 3'd3};
      4'd14: return {3'b110, 3'd4};
      default: return 6'd0;
    endcase
  endfunction

  task automatic check_rsp(input string tag, input logic [1:0] ec, input logic [2:0] erwx,
                           input logic [2:0] ecm, input logic [31:0] epa);
    n_run++;
    if ({rsp_valid, rsp_cause, rsp_rights, rsp_cache, rsp_paddr} !== {1'b1, ec, erwx, ecm, epa}) begin
      n_fail++;
      $display("FAIL %s: got v=%0b cause=%0d rwx=%03b cache=%0d pa=%08h, want v=1 cause=%0d rwx=%03b cache=%0d pa=%08h",
               tag, rsp_valid, rsp_cause, rsp_rights, rsp_cache, rsp_paddr, ec, erwx, ecm, epa);
    end
  endtask

  task automatic tbl_write(input logic side, input logic [2:0] i, input logic [2:0] b,
                           input logic [3:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_idx = i; wr_base = b; wr_attr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic side, input logic [1:0] acc, input logic byp,
                       input logic [31:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_side = side; req_acc = acc; bypass_mode = byp; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang, want completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state of the response
    n_run++;
    if ({rsp_valid, rsp_cause, rsp_paddr} !== 35'd0) begin
      n_fail++;
      $display("FAIL R7 reset: got v=%0b cause=%0d pa=%08h, want 0 0 0", rsp_valid, rsp_cause, rsp_paddr);
    end
    rst = 1'b0;

    // R2: identity map, code 2, on both sides
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++) begin
        issue(1'(s), 2'd2, 1'b0, {3'(i), 29'h0ABC});
        check_rsp("R2 reset entry", 2'd0, 3'b111, 3'd1, {3'(i), 29'h0ABC});
      end

    // setup for the vector table (R1, R5)
    tbl_write(1'b1, 3'd1, 3'd5, 4'd0);
    tbl_write(1'b1, 3'd3, 3'd0, 4'd3);
    tbl_write(1'b1, 3'd7, 3'd7, 4'd14);
    tbl_write(1'b0, 3'd1, 3'd2, 4'd3);

    // R1 R3 R4 R6 vectors
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][75], VEC[v][74:73], VEC[v][72], VEC[v][71:40]);
      check_rsp($sformatf("R1/R3/R4/R6 vector %0d", v), VEC[v][39:38], VEC[v][37:35],
                VEC[v][34:32], VEC[v][31:0]);
    end

    // R3: every code in table mode, data side region 4
    for (int c = 0; c < 16; c++) begin
      logic [5:0] e;
      e = exp_dec(4'(c));
      tbl_write(1'b1, 3'd4, 3'd4, 4'(c));
      issue(1'b1, 2'd0, 1'b0, 32'h8000_1234);
      check_rsp($sformatf("R3 code %0d", c), e[5] ? 2'd0 : 2'd2, e[5:3], e[2:0], 32'h8000_1234);
    end

    // R5: instruction-side write leaves data side alone
    tbl_write(1'b0, 3'd0, 3'd0, 4'd15);
    issue(1'b1, 2'd0, 1'b0, 32'h0000_0040);
    check_rsp("R5 other side untouched", 2'd0, 3'b111, 3'd1, 32'h0000_0040);
    issue(1'b0, 2'd2, 1'b0, 32'h0000_0040);
    check_rsp("R5 written side changed", 2'd1, 3'b000, 3'd0, 32'h0000_0040);

    // R8: write and request in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_side = 1'b1; wr_idx = 3'd2; wr_base = 3'd6; wr_attr = 4'd15;
    req_valid = 1'b1; req_side = 1'b1; req_acc = 2'd0; bypass_mode = 1'b0; req_addr = 32'h4000_0000;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check_rsp("R8 old entry seen", 2'd0, 3'b111, 3'd1, 32'h4000_0000);
    issue(1'b1, 2'd0, 1'b0, 32'h4000_0000);
    check_rsp("R8 new entry next", 2'd2, 3'b000, 3'd0, 32'hC000_0000);

    // R7: fields hold and valid drops without a request
    held = rsp_paddr;
    req_addr = 32'h1234_5678;
    @(negedge clk);
    n_run++;
    if (rsp_valid !== 1'b0 || rsp_paddr !== held) begin
      n_fail++;
      $display("FAIL R7 hold: got v=%0b pa=%08h, want v=0 pa=%08h", rsp_valid, rsp_paddr, held);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule